// File: doc/BRIEF.md
# Multi-channel gamma lookup table

This block applies gamma correction to the pixel streams of a display compositor that has several output channels. One shared table memory holds a 256-entry, 8-bit curve for each colour component of each channel. Software fills the memory through two registers. The first is a table pointer register that holds the address and two control bits. The second is a data port. Each data-port write stores one entry. When auto-stepping is on, the pointer moves forward after each data-port write, so a whole channel can be streamed in without setting the address again.

Each channel has a stream of 24-bit RGB pixels qualified by a valid flag. When the channel's gamma enable is high, each component is replaced by its table entry. When the enable is low, the pixel passes through unchanged. Both paths add one register stage. The table storage is powered only while at least one channel has gamma enabled or software holds the force-on bit. Whenever the storage is unpowered, its contents are lost, and the model shows this by zeroing them. Software must reload the tables after every power-down.

Top module: `gamma_lut`

## Requirements
- R1: The entry for channel `ch`, component `c` (0 = red, 1 = green, 2 = blue) and input value `i` is at table address `ch*768 + c*256 + i`. A pixel is packed as red in bits [23:16], green in [15:8] and blue in [7:0], and channel `ch` occupies bits `[ch*24 +: 24]` of the pixel buses.
- R2: A register write at offset 0x78 loads the pointer from bits [11:0], the auto-step bit from bit 31 and the force-on bit from bit 30. While `regOfs` is 0x78, `regRdata` returns the auto-step bit in bit 31, the force-on bit in bit 30, zeros in bits [29:12] and the current pointer in bits [11:0]. Any other offset reads as zero.
- R3: A register write at offset 0xE0 stores bits [7:0] at the pointer address. With auto-step set, the pointer then advances by one, wrapping from 4095 to 0. With auto-step clear, the pointer keeps its value.
- R4: A data write whose pointer is 2304 or above changes no table entry, but the pointer still advances when auto-step is set.
- R5: A channel with gamma enabled outputs the table entries of its input components one clock after the input. `pixOutValid` is `pixInValid` delayed by one clock.
- R6: A channel with gamma disabled outputs its input pixel unchanged, one clock later.
- R7: `sramPowerOn` is high exactly when the force-on bit is set or any bit of `gammaEn` is high. It follows `gammaEn` in the same cycle.
- R8: At every clock edge where `sramPowerOn` is low, all table entries become zero and any data write at that edge is discarded. After power returns, lookups read zero until the entries are written again.
- R9: When a data write and a lookup hit the same entry on the same edge, the lookup returns the value held before the write.
- R10: Reset clears the pointer, auto-step and force-on bits, output valids and output pixels, and zeroes the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous for the control and output registers |
| regOfs | input | 8 | Register byte offset for reads and writes |
| regWe | input | 1 | Register write strobe, one write per high cycle |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from `regOfs` |
| gammaEn | input | 3 | Per-channel gamma enable |
| pixInValid | input | 3 | Per-channel input pixel valid |
| pixIn | input | 72 | Input pixels, 24 bits per channel |
| pixOutValid | output | 3 | Per-channel output pixel valid |
| pixOut | output | 72 | Output pixels, 24 bits per channel |
| sramPowerOn | output | 1 | Power request for the table storage |

## Verification
The assertions assume that `regWe` is a clean single-cycle strobe that selects one offset per cycle. They also assume that `gammaEn`, `pixInValid` and the register inputs are stable around each rising edge, and that reset is low from time zero. The bench changes every input only on the falling clock edge. It holds reset for several cycles before releasing it, and it never changes the enables within a cycle, so those assumptions hold across table loading, streaming, power cycling and pointer wrap.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  parameter int NUM_CH    = 3;
  parameter int COMP_W    = 8;
  parameter int LUT_DEPTH = 256;
  parameter int NUM_COMP  = 3;
  parameter int ADDR_W    = 12;
  parameter int REG_W     = 32;
  parameter int OFS_W     = 8;

  localparam int CH_SPAN     = NUM_COMP * LUT_DEPTH;
  localparam int TABLE_SIZE  = NUM_CH * CH_SPAN;
  localparam int PIX_W       = NUM_COMP * COMP_W;
  localparam int AUTOINC_BIT = REG_W - 1;
  localparam int FORCE_BIT   = REG_W - 2;

  // Strobes from the register control to the table datapath
  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [COMP_W-1:0] wrData;
    logic              sramOn;
  } tbl_cmd_t;
endpackage

// File: rtl/gamma_lut_ctrl.sv
module gamma_lut_ctrl
  import gamma_pkg::*;
#(
  parameter logic [OFS_W-1:0] ADDR_OFS = 8'h78,
  parameter logic [OFS_W-1:0] DATA_OFS = 8'hE0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OFS_W-1:0]  regOfs,
  input  logic              regWe,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic [NUM_CH-1:0] gammaEn,
  output tbl_cmd_t          cmd,
  output logic [ADDR_W-1:0] curAddr,
  output logic              autoIncOn
);
  localparam logic [ADDR_W-1:0] LAST_ENTRY = ADDR_W'(TABLE_SIZE - 1);

  logic forceOnQ;
  logic addrHit;
  logic dataHit;
  logic sramOn;

  assign addrHit = regWe && (regOfs == ADDR_OFS);
  assign dataHit = regWe && (regOfs == DATA_OFS);
  assign sramOn  = forceOnQ || (|gammaEn);

  // Table pointer and its control bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      autoIncOn <= 1'b0;
      forceOnQ  <= 1'b0;
    end else if (addrHit) begin
      curAddr   <= regWdata[ADDR_W-1:0];
      autoIncOn <= regWdata[AUTOINC_BIT];
      forceOnQ  <= regWdata[FORCE_BIT];
    end else if (dataHit && autoIncOn) begin
      curAddr <= curAddr + 1'b1;
    end
  end

  // Strobes towards the storage
  always_comb begin
    cmd.wrEn   = dataHit && sramOn && (curAddr <= LAST_ENTRY);
    cmd.wrAddr = curAddr;
    cmd.wrData = regWdata[COMP_W-1:0];
    cmd.sramOn = sramOn;
  end

  // Read mux
  always_comb begin
    regRdata = '0;
    if (regOfs == ADDR_OFS) begin
      regRdata[AUTOINC_BIT]  = autoIncOn;
      regRdata[FORCE_BIT]    = forceOnQ;
      regRdata[ADDR_W-1:0]   = curAddr;
    end
  end
endmodule

// File: rtl/gamma_lut_dp.sv
module gamma_lut_dp
  import gamma_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  tbl_cmd_t                cmd,
  input  logic [NUM_CH-1:0]       gammaEn,
  input  logic [NUM_CH-1:0]       pixInValid,
  input  logic [NUM_CH*PIX_W-1:0] pixIn,
  output logic [NUM_CH-1:0]       pixOutValid,
  output logic [NUM_CH*PIX_W-1:0] pixOut
);
  logic [COMP_W-1:0] tableMem [TABLE_SIZE];

  // Shared table; power loss modelled as zeroing every entry
  always_ff @(posedge clk) begin
    if (!rstN || !cmd.sramOn) begin
      for (int e = 0; e < TABLE_SIZE; e++) tableMem[e] <= '0;
    end else if (cmd.wrEn) begin
      tableMem[cmd.wrAddr] <= cmd.wrData;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pixOutValid[ch] <= 1'b0;
      else       pixOutValid[ch] <= pixInValid[ch];
    end

    for (genvar comp = 0; comp < NUM_COMP; comp++) begin : g_comp
      localparam int BASE = ch * CH_SPAN + comp * LUT_DEPTH;
      localparam int LSB  = ch * PIX_W + (NUM_COMP - 1 - comp) * COMP_W;

      logic [COMP_W-1:0] inVal;
      logic [COMP_W-1:0] lutVal;
      logic [ADDR_W-1:0] rdAddr;

      assign inVal  = pixIn[LSB +: COMP_W];
      assign rdAddr = ADDR_W'(BASE) + ADDR_W'(inVal);
      assign lutVal = tableMem[rdAddr];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            pixOut[LSB +: COMP_W] <= '0;
        else if (gammaEn[ch]) pixOut[LSB +: COMP_W] <= lutVal;
        else                  pixOut[LSB +: COMP_W] <= inVal;
      end
    end
  end
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
  import gamma_pkg::*;
#(
  parameter logic [OFS_W-1:0] ADDR_OFS = 8'h78,
  parameter logic [OFS_W-1:0] DATA_OFS = 8'hE0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [OFS_W-1:0]        regOfs,
  input  logic                    regWe,
  input  logic [REG_W-1:0]        regWdata,
  output logic [REG_W-1:0]        regRdata,
  input  logic [NUM_CH-1:0]       gammaEn,
  input  logic [NUM_CH-1:0]       pixInValid,
  input  logic [NUM_CH*PIX_W-1:0] pixIn,
  output logic [NUM_CH-1:0]       pixOutValid,
  output logic [NUM_CH*PIX_W-1:0] pixOut,
  output logic                    sramPowerOn
);
  tbl_cmd_t          cmd;
  logic [ADDR_W-1:0] curAddr;
  logic              autoIncOn;

  gamma_lut_ctrl #(.ADDR_OFS(ADDR_OFS), .DATA_OFS(DATA_OFS)) u_ctrl (
    .clk(clk), .rstN(rstN), .regOfs(regOfs), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .gammaEn(gammaEn),
    .cmd(cmd), .curAddr(curAddr), .autoIncOn(autoIncOn)
  );

  gamma_lut_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .gammaEn(gammaEn),
    .pixInValid(pixInValid), .pixIn(pixIn),
    .pixOutValid(pixOutValid), .pixOut(pixOut)
  );

  assign sramPowerOn = cmd.sramOn;
endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk
  import gamma_pkg::*;
#(
  parameter logic [OFS_W-1:0] ADDR_OFS = 8'h78,
  parameter logic [OFS_W-1:0] DATA_OFS = 8'hE0
) (
  input logic              clk,
  input logic              rstN,
  input logic [OFS_W-1:0]  regOfs,
  input logic              regWe,
  input logic [REG_W-1:0]  regWdata,
  input logic [REG_W-1:0]  regRdata,
  input logic [NUM_CH-1:0] gammaEn,
  input logic [NUM_CH-1:0] pixInValid,
  input logic [NUM_CH-1:0] pixOutValid,
  input logic              sramPowerOn,
  input tbl_cmd_t          cmd,
  input logic [ADDR_W-1:0] curAddr,
  input logic              autoIncOn
);
  localparam logic [ADDR_W-1:0] LAST_ENTRY = ADDR_W'(TABLE_SIZE - 1);

  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regOfs == ADDR_OFS) |=> curAddr == $past(regWdata[ADDR_W-1:0]));

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regOfs == DATA_OFS && autoIncOn) |=> curAddr == ADDR_W'($past(curAddr) + 1'b1));

  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regOfs == DATA_OFS && !autoIncOn) |=> $stable(curAddr));

  assert_write_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrEn |-> cmd.wrAddr <= LAST_ENTRY);

  assert_valid_delay_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> pixOutValid == $past(pixInValid));

  assert_power_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regOfs == ADDR_OFS) |-> sramPowerOn == (regRdata[FORCE_BIT] || (|gammaEn)));

  assert_no_write_unpowered_R8: assert property (@(posedge clk) disable iff (!rstN)
    !sramPowerOn |-> !cmd.wrEn);
endmodule

bind gamma_lut gamma_lut_chk #(.ADDR_OFS(ADDR_OFS), .DATA_OFS(DATA_OFS)) u_chk (
  .clk(clk), .rstN(rstN), .regOfs(regOfs), .regWe(regWe), .regWdata(regWdata),
  .regRdata(regRdata), .gammaEn(gammaEn), .pixInValid(pixInValid),
  .pixOutValid(pixOutValid), .sramPowerOn(sramPowerOn), .cmd(cmd),
  .curAddr(curAddr), .autoIncOn(autoIncOn)
);

// File: tb/gamma_lut_tb.sv
module gamma_lut_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NCH   = 3;
  localparam int SPAN  = 768;
  localparam int TSIZE = 2304;
  localparam logic [7:0] OFS_PTR  = 8'h78;
  localparam logic [7:0] OFS_DATA = 8'hE0;
  localparam logic [31:0] AUTO  = 32'h8000_0000;
  localparam logic [31:0] FORCE = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regOfs = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [2:0]  gammaEn = '0;
  logic [2:0]  pixInValid = '0;
  logic [71:0] pixIn = '0;
  logic [2:0]  pixOutValid;
  logic [71:0] pixOut;
  logic        sramPowerOn;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gamma_lut u_dut (
    .clk(clk), .rstN(rstN), .regOfs(regOfs), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .gammaEn(gammaEn), .pixInValid(pixInValid), .pixIn(pixIn),
    .pixOutValid(pixOutValid), .pixOut(pixOut), .sramPowerOn(sramPowerOn)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int ch, input int c, input int i);
    return 8'((i * 3 + ch * 70 + c * 29 + 5) & 255);
  endfunction

  // Behavioural reference model
  logic [7:0]  mMem [TSIZE];
  int          mAddr;
  bit          mAuto, mForce;
  logic [2:0]  eValid;
  logic [71:0] ePix;
  string       chTag [NCH];
  bit          pwr;

  always @(posedge clk) begin
    if (!rstN) begin
      mAddr = 0; mAuto = 0; mForce = 0; eValid = '0; ePix = '0;
      for (int e = 0; e < TSIZE; e++) mMem[e] = 8'h00;
      for (int ch = 0; ch < NCH; ch++) chTag[ch] = "R10";
    end else begin
      pwr = mForce || (gammaEn != 0);
      for (int ch = 0; ch < NCH; ch++) begin
        eValid[ch] = pixInValid[ch];
        chTag[ch]  = gammaEn[ch] ? "R5" : "R6";
        for (int c = 0; c < 3; c++) begin
          logic [7:0] b;
          b = pixIn[ch*24 + (2-c)*8 +: 8];
          ePix[ch*24 + (2-c)*8 +: 8] = gammaEn[ch] ? mMem[ch*SPAN + c*256 + int'(b)] : b;
        end
      end
      if (!pwr) begin
        for (int e = 0; e < TSIZE; e++) mMem[e] = 8'h00;
      end else if (regWe && regOfs == OFS_DATA && mAddr < TSIZE) begin
        mMem[mAddr] = regWdata[7:0];
      end
      if (regWe && regOfs == OFS_PTR) begin
        mAddr = int'(regWdata[11:0]); mAuto = regWdata[31]; mForce = regWdata[30];
      end else if (regWe && regOfs == OFS_DATA && mAuto) begin
        mAddr = (mAddr + 1) % 4096;
      end
    end
    #1;
    check(pixOutValid == eValid, "R5 valid", 32'(pixOutValid), 32'(eValid));
    for (int ch = 0; ch < NCH; ch++)
      check(pixOut[ch*24 +: 24] == ePix[ch*24 +: 24], chTag[ch],
            32'(pixOut[ch*24 +: 24]), 32'(ePix[ch*24 +: 24]));
    begin
      logic [31:0] eRd;
      eRd = (regOfs == OFS_PTR) ? {mAuto, mForce, 18'b0, 12'(mAddr)} : 32'h0;
      check(regRdata == eRd, "R2 readback", regRdata, eRd);
    end
    check(sramPowerOn == (mForce || gammaEn != 0), "R7 power", 32'(sramPowerOn),
          32'(mForce || gammaEn != 0));
  end

  task automatic regWrite(input logic [7:0] ofs, input logic [31:0] data);
    @(negedge clk);
    regOfs = ofs; regWe = 1'b1; regWdata = data;
  endtask

  task automatic readPtr(input logic [31:0] exp, input string tag);
    @(negedge clk);
    regWe = 1'b0; regOfs = OFS_PTR;
    #1;
    check(regRdata == exp, tag, regRdata, exp);
  endtask

  task automatic lookOne(input logic [2:0] en, input int ch, input logic [23:0] pix,
                         input logic [23:0] exp, input string tag);
    @(negedge clk);
    regWe = 1'b0; gammaEn = en; pixInValid = 3'(1 << ch); pixIn = '0;
    pixIn[ch*24 +: 24] = pix;
    @(posedge clk); #1;
    check(pixOut[ch*24 +: 24] == exp, tag, 32'(pixOut[ch*24 +: 24]), 32'(exp));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    repeat (4) @(negedge clk);
    regOfs = OFS_PTR;
    #1;
    check(regRdata == 32'h0, "R10 pointer reset", regRdata, 32'h0);
    check(pixOutValid == 3'b0 && pixOut == '0, "R10 outputs reset", 32'(pixOutValid), 32'h0);
    @(negedge clk); rstN = 1'b1;

    // Full load of every table (R1 layout)
    regWrite(OFS_PTR, AUTO | FORCE);
    for (int ch = 0; ch < NCH; ch++)
      for (int c = 0; c < 3; c++)
        for (int i = 0; i < 256; i++)
          regWrite(OFS_DATA, {24'h0, pat(ch, c, i)});
    readPtr(AUTO | FORCE | 32'd2304, "R3 pointer after load");

    // Writes that run past the end of the table
    regWrite(OFS_PTR, AUTO | FORCE | 32'd2300);
    for (int k = 0; k < 8; k++) regWrite(OFS_DATA, 32'h11 + 32'(k));
    readPtr(AUTO | FORCE | 32'd2308, "R4 pointer past end");

    lookOne(3'b010, 1, {8'd10, 8'd20, 8'd30}, {pat(1,0,10), pat(1,1,20), pat(1,2,30)}, "R1 layout ch1");
    lookOne(3'b001, 0, {8'd0, 8'd128, 8'd255}, {pat(0,0,0), pat(0,1,128), pat(0,2,255)}, "R1 layout ch0");
    lookOne(3'b100, 2, {8'd7, 8'd9, 8'd255}, {pat(2,0,7), pat(2,1,9), 8'h14}, "R4 last entry");
    lookOne(3'b100, 2, {8'd1, 8'd2, 8'd251}, {pat(2,0,1), pat(2,1,2), pat(2,2,251)}, "R4 untouched entry");
    lookOne(3'b000, 0, 24'hA1B2C3, 24'hA1B2C3, "R6 passthrough");

    // Fixed pointer writes
    regWrite(OFS_PTR, FORCE | 32'd5);
    regWrite(OFS_DATA, 32'h77);
    regWrite(OFS_DATA, 32'h78);
    readPtr(FORCE | 32'd5, "R3 pointer holds");
    lookOne(3'b001, 0, {8'd5, 8'd0, 8'd0}, {8'h78, pat(0,1,0), pat(0,2,0)}, "R3 overwrite");

    // Write and lookup of the same entry on one edge
    @(negedge clk);
    regOfs = OFS_DATA; regWe = 1'b1; regWdata = 32'h99;
    gammaEn = 3'b001; pixInValid = 3'b001; pixIn = '0; pixIn[23:16] = 8'd5;
    @(posedge clk); #1;
    check(pixOut[23:16] == 8'h78, "R9 old value", 32'(pixOut[23:16]), 32'h78);
    @(negedge clk); regWe = 1'b0;
    @(posedge clk); #1;
    check(pixOut[23:16] == 8'h99, "R9 new value", 32'(pixOut[23:16]), 32'h99);

    // Mixed streaming
    seed = 17;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      seed = seed * 1103515245 + 12345;
      pixIn[31:0] = 32'(seed);
      seed = seed * 1103515245 + 12345;
      pixIn[63:32] = 32'(seed);
      seed = seed * 1103515245 + 12345;
      pixIn[71:64] = 8'(seed >> 8);
      pixInValid = 3'(seed >> 20);
      gammaEn = 3'(n / 50);
    end

    // Power-down loses the tables
    @(negedge clk); gammaEn = 3'b000; pixInValid = '0;
    regWrite(OFS_PTR, AUTO);
    regWrite(OFS_DATA, 32'h55);
    regWrite(OFS_DATA, 32'h56);
    readPtr(AUTO | 32'd2, "R3 pointer steps while unpowered");
    check(sramPowerOn == 1'b0, "R7 power off", 32'(sramPowerOn), 32'h0);
    lookOne(3'b001, 0, {8'd5, 8'd6, 8'd7}, 24'h000000, "R8 lost contents");
    check(sramPowerOn == 1'b1, "R7 power on", 32'(sramPowerOn), 32'h1);
    lookOne(3'b001, 0, {8'd0, 8'd1, 8'd200}, 24'h000000, "R8 discarded writes");
    regWrite(OFS_PTR, AUTO);
    regWrite(OFS_DATA, 32'hAB);
    regWrite(OFS_DATA, 32'hAC);
    regWrite(OFS_DATA, 32'hAD);
    lookOne(3'b001, 0, {8'd1, 8'd0, 8'd0}, {8'hAC, 8'h00, 8'h00}, "R8 reload");

    // Pointer wrap
    regWrite(OFS_PTR, AUTO | 32'd4094);
    regWrite(OFS_DATA, 32'h01);
    regWrite(OFS_DATA, 32'h02);
    regWrite(OFS_DATA, 32'h03);
    readPtr(AUTO | 32'd1, "R3 pointer wrap");
    lookOne(3'b001, 0, {8'd0, 8'd0, 8'd0}, {8'h03, 8'h00, 8'h00}, "R3 write after wrap");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule